// File: doc/BRIEF.md
# Dot Clock Source Selector and Divider

This block picks the pixel clock source for a display controller out of a set of reference tick inputs. Each tick input is a one-cycle enable in the system clock domain. It divides the chosen source down to a pixel clock enable. The select code is assembled from bits scattered across three configuration bytes and the miscellaneous output byte. How that code maps onto the references depends on the board generation. Older boards carry four crystals, feed `ref_tick[3:0]`, and come in two revisions that take the upper select bit from different bytes. Newer boards have a clock synthesizer whose sixteen outputs feed all of `ref_tick[15:0]`.

A two-bit field sets a divisor of 1, 2, 3 or 4. The divisor counts ticks of the selected source, and pulses come out evenly spaced, including for the odd divisor. The block also reports the nominal frequency of the current selection in kHz. A status flag marks the selections that have no reference behind them. When the effective selection or the divisor changes, the divider starts counting again from zero.

Top module: `dclk_select_div`

## Requirements
- R1: With `board_mode` 2'b10 or 2'b11 (synthesizer), the source index is {`xr_sel_late[4]`, `xr_sel_gen[1]`, `misc_byte[3]`, `misc_byte[2]`}, and every one of its 16 values selects `ref_tick` of that index.
- R2: With `board_mode` 2'b00 or 2'b01 (crystal), the 3-bit code is {ext, `misc_byte[3]`, `misc_byte[2]`}. Here ext is `xr_sel_early[6]` in mode 2'b00 and `xr_sel_late[4]` in mode 2'b01. Codes 0 and 5 select `ref_tick[0]`, 1 selects `ref_tick[1]`, 3 and 4 select `ref_tick[2]`, and 7 selects `ref_tick[3]`.
- R3: Crystal codes 2 and 6 are spares. While a spare is selected, `pix_en` stays low, and `sel_spare` is high one cycle after the selection is presented.
- R4: `xr_div[7:6]` values 00, 01, 10 and 11 give divisors N = 1, 2, 3 and 4. With the selection unchanged, `pix_en` is high for one cycle, the cycle after each Nth counted tick of the selected source.
- R5: The effective selection is the board class (crystal or synthesizer) plus its code. When the selection or the divisor differs from the previous cycle, the count restarts at zero and that cycle's tick is not counted. A mode change that keeps the same effective code does not restart the count.
- R6: `freq_khz` reports the nominal frequency of the selection one cycle after it is presented. The values are listed below; spares report 0.
  - Crystal codes 0..7: 50175, 56644, 0, 44900, 44900, 50175, 0, 36000.
  - Synthesizer indices 0..7: 30240, 32000, 37500, 39000, 40000, 56644, 75000, 65000.
  - Synthesizer indices 8..15: 42954, 48771, 16657, 36000, 50350, 56640, 28322, 44900.
- R7: While `rst_n` is low, `pix_en`, `freq_khz` and `sel_spare` are 0. The count and the stored selection clear to zero.
- R8: Ticks on reference inputs other than the selected one do not affect `pix_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| board_mode | input | 2 | 00 crystal early rev, 01 crystal late rev, 1x synthesizer |
| xr_sel_early | input | 8 | Config byte; bit 6 is the crystal select bit on early boards |
| xr_sel_late | input | 8 | Config byte; bit 4 is the upper select bit on late crystal and synthesizer boards |
| xr_sel_gen | input | 8 | Config byte; bit 1 is a synthesizer select bit |
| xr_div | input | 8 | Config byte; bits 7:6 hold the divisor minus one |
| misc_byte | input | 8 | Miscellaneous output byte; bits 3:2 are low select bits |
| ref_tick | input | 16 | Reference clock enables, one per source |
| pix_en | output | 1 | Divided pixel clock enable |
| freq_khz | output | 17 | Nominal frequency of the selection in kHz |
| sel_spare | output | 1 | Selection has no reference behind it |

## Verification
A configuration change and a terminal-count tick of the selected source can land in the same cycle. The restart must then win, so no pulse issues and the count returns to zero. The bench provokes this by switching code or divisor exactly on the cycle that would complete a divided period, in the directed phase and by chance in the random phase. A cycle-accurate model of the selection and count, built from the requirements, judges every cycle. That model also covers a spare selection arriving in the same cycle as ticks on every input, where the spare must stay silent.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

  localparam int REF_NUM = 16;
  localparam int IDX_W   = $clog2(REF_NUM);
  localparam int DIV_W   = 2;
  localparam int FREQ_W  = 17;
  localparam int XTAL_W  = 3;

  typedef enum logic [1:0] {
    BOARD_XTAL_EARLY = 2'b00,
    BOARD_XTAL_LATE  = 2'b01,
    BOARD_SYNTH      = 2'b10,
    BOARD_SYNTH_ALT  = 2'b11
  } board_mode_e;

  typedef struct packed {
    logic             synth;
    logic [IDX_W-1:0] code;
  } sel_key_t;

  function automatic logic [FREQ_W-1:0] nominal_khz(sel_key_t k);
    logic [FREQ_W-1:0] f;
    if (k.synth) begin
      case (k.code)
        4'd0:  f = FREQ_W'(30240);
        4'd1:  f = FREQ_W'(32000);
        4'd2:  f = FREQ_W'(37500);
        4'd3:  f = FREQ_W'(39000);
        4'd4:  f = FREQ_W'(40000);
        4'd5:  f = FREQ_W'(56644);
        4'd6:  f = FREQ_W'(75000);
        4'd7:  f = FREQ_W'(65000);
        4'd8:  f = FREQ_W'(42954);
        4'd9:  f = FREQ_W'(48771);
        4'd10: f = FREQ_W'(16657);
        4'd11: f = FREQ_W'(36000);
        4'd12: f = FREQ_W'(50350);
        4'd13: f = FREQ_W'(56640);
        4'd14: f = FREQ_W'(28322);
        default: f = FREQ_W'(44900);
      endcase
    end else begin
      case (k.code[XTAL_W-1:0])
        3'd0: f = FREQ_W'(50175);
        3'd1: f = FREQ_W'(56644);
        3'd3: f = FREQ_W'(44900);
        3'd4: f = FREQ_W'(44900);
        3'd5: f = FREQ_W'(50175);
        3'd7: f = FREQ_W'(36000);
        default: f = '0;
      endcase
    end
    return f;
  endfunction

endpackage

// File: rtl/dclk_rst_sync.sv
module dclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n_in) begin
          if (!rst_n_in) chain_q[s] <= 1'b0;
          else           chain_q[s] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n_in) begin
          if (!rst_n_in) chain_q[s] <= 1'b0;
          else           chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/dclk_src_decode.sv
module dclk_src_decode
  import dclk_pkg::*;
(
  input  logic [1:0]        board_mode,
  input  logic              bit_early,
  input  logic              bit_late,
  input  logic              bit_gen,
  input  logic [1:0]        misc_sel,
  output sel_key_t          key,
  output logic [IDX_W-1:0]  src_idx,
  output logic              src_valid,
  output logic [FREQ_W-1:0] khz
);

  logic              is_synth;
  logic              ext_bit;
  logic [XTAL_W-1:0] xcode;

  always_comb begin
    is_synth = board_mode[1];
    ext_bit  = (board_mode == BOARD_XTAL_EARLY) ? bit_early : bit_late;
    xcode    = {ext_bit, misc_sel};

    key.synth = is_synth;
    if (is_synth) key.code = {bit_late, bit_gen, misc_sel};
    else          key.code = {1'b0, xcode};

    src_valid = 1'b1;
    src_idx   = '0;
    if (is_synth) begin
      src_idx = key.code;
    end else begin
      case (xcode)
        3'd0, 3'd5: src_idx = IDX_W'(0);
        3'd1:       src_idx = IDX_W'(1);
        3'd3, 3'd4: src_idx = IDX_W'(2);
        3'd7:       src_idx = IDX_W'(3);
        default:    src_valid = 1'b0;
      endcase
    end

    khz = nominal_khz(key);
  end

  // R2
  always_comb begin
    if (!key.synth && src_valid) begin
      xtal_tap_chk: assert (src_idx < IDX_W'(4))
        else $error("crystal selection routed beyond the four crystal taps");
    end
  end

endmodule

// File: rtl/dclk_div.sv
module dclk_div
  import dclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  sel_key_t         key_i,
  input  logic [DIV_W-1:0] ratio_i,
  input  logic             tick_i,
  output logic             pix_en_o
);

  sel_key_t         key_q,   key_d;
  logic [DIV_W-1:0] ratio_q, ratio_d;
  logic [DIV_W-1:0] cnt_q,   cnt_d;
  logic             pix_q,   pix_d;
  logic             cfg_chg;

  always_comb begin
    cfg_chg = (key_i != key_q) || (ratio_i != ratio_q);
    key_d   = key_i;
    ratio_d = ratio_i;
    cnt_d   = cnt_q;
    pix_d   = 1'b0;
    if (cfg_chg) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == ratio_q) begin
        pix_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      ratio_q <= '0;
      cnt_q   <= '0;
      pix_q   <= 1'b0;
    end else begin
      key_q   <= key_d;
      ratio_q <= ratio_d;
      cnt_q   <= cnt_d;
      pix_q   <= pix_d;
    end
  end

  assign pix_en_o = pix_q;

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ratio_q)
    else $error("divider count beyond divisor");

  // R4
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_q |-> $past(tick_i))
    else $error("pixel enable without a source tick");

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_i != $past(key_i) || ratio_i != $past(ratio_i)) |=> (cnt_q == '0 && !pix_q))
    else $error("configuration change did not restart the divider");

endmodule

// File: rtl/dclk_select_div.sv
module dclk_select_div
  import dclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          board_mode,
  input  logic [7:0]          xr_sel_early,
  input  logic [7:0]          xr_sel_late,
  input  logic [7:0]          xr_sel_gen,
  input  logic [7:0]          xr_div,
  input  logic [7:0]          misc_byte,
  input  logic [REF_NUM-1:0]  ref_tick,
  output logic                pix_en,
  output logic [FREQ_W-1:0]   freq_khz,
  output logic                sel_spare
);

  localparam int EARLY_BIT = 6;
  localparam int LATE_BIT  = 4;
  localparam int GEN_BIT   = 1;
  localparam int DIV_LSB   = 6;
  localparam int MISC_LSB  = 2;

  logic              rst_n_core;
  sel_key_t          key;
  logic [IDX_W-1:0]  src_idx;
  logic              src_valid;
  logic [FREQ_W-1:0] khz;
  logic              sel_tick;
  logic [FREQ_W-1:0] freq_d, freq_q;
  logic              spare_d, spare_q;

  dclk_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_core)
  );

  dclk_src_decode decode_i (
    .board_mode (board_mode),
    .bit_early  (xr_sel_early[EARLY_BIT]),
    .bit_late   (xr_sel_late[LATE_BIT]),
    .bit_gen    (xr_sel_gen[GEN_BIT]),
    .misc_sel   (misc_byte[MISC_LSB+1:MISC_LSB]),
    .key        (key),
    .src_idx    (src_idx),
    .src_valid  (src_valid),
    .khz        (khz)
  );

  always_comb begin
    sel_tick = src_valid && ref_tick[src_idx];
    freq_d   = khz;
    spare_d  = !src_valid;
  end

  dclk_div div_i (
    .clk      (clk),
    .rst_n    (rst_n_core),
    .key_i    (key),
    .ratio_i  (xr_div[DIV_LSB+DIV_W-1:DIV_LSB]),
    .tick_i   (sel_tick),
    .pix_en_o (pix_en)
  );

  always_ff @(posedge clk or negedge rst_n_core) begin
    if (!rst_n_core) begin
      freq_q  <= '0;
      spare_q <= 1'b0;
    end else begin
      freq_q  <= freq_d;
      spare_q <= spare_d;
    end
  end

  assign freq_khz  = freq_q;
  assign sel_spare = spare_q;

  // R3
  spare_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_core)
    sel_spare |-> !pix_en)
    else $error("pixel enable while a spare is selected");

  // R6
  spare_freq_chk: assert property (@(posedge clk) disable iff (!rst_n_core)
    sel_spare |-> (freq_khz == '0))
    else $error("spare selection reports a frequency");

endmodule

// File: tb/dclk_select_div_tb.sv
module dclk_select_div_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [1:0]  board_mode;
  logic [7:0]  xr_sel_early, xr_sel_late, xr_sel_gen, xr_div, misc_byte;
  logic [15:0] ref_tick;
  logic        pix_en;
  logic [16:0] freq_khz;
  logic        sel_spare;

  int    n_vec;
  int    n_bad;
  bit    done;
  string tag;

  logic [4:0]  m_key;
  logic [1:0]  m_ratio;
  logic [1:0]  m_cnt;
  logic        exp_pix;
  logic [16:0] exp_freq;
  logic        exp_spare;

  dclk_select_div dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .board_mode   (board_mode),
    .xr_sel_early (xr_sel_early),
    .xr_sel_late  (xr_sel_late),
    .xr_sel_gen   (xr_sel_gen),
    .xr_div       (xr_div),
    .misc_byte    (misc_byte),
    .ref_tick     (ref_tick),
    .pix_en       (pix_en),
    .freq_khz     (freq_khz),
    .sel_spare    (sel_spare)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {synth, code[3:0]} per R1 and R2
  function automatic logic [4:0] key_of();
    logic e;
    if (board_mode[1])
      return {1'b1, xr_sel_late[4], xr_sel_gen[1], misc_byte[3:2]};
    e = (board_mode == 2'b00) ? xr_sel_early[6] : xr_sel_late[4];
    return {1'b0, 1'b0, e, misc_byte[3:2]};
  endfunction

  // {valid, index}
  function automatic logic [4:0] src_of(logic [4:0] k);
    if (k[4]) return {1'b1, k[3:0]};
    case (k[2:0])
      3'd0, 3'd5: return 5'b1_0000;
      3'd1:       return 5'b1_0001;
      3'd3, 3'd4: return 5'b1_0010;
      3'd7:       return 5'b1_0011;
      default:    return 5'b0_0000;
    endcase
  endfunction

  function automatic logic [16:0] khz_of(logic [4:0] k);
    int t;
    if (k[4]) begin
      case (k[3:0])
        0: t = 30240;  1: t = 32000;  2: t = 37500;  3: t = 39000;
        4: t = 40000;  5: t = 56644;  6: t = 75000;  7: t = 65000;
        8: t = 42954;  9: t = 48771; 10: t = 16657; 11: t = 36000;
        12: t = 50350; 13: t = 56640; 14: t = 28322; default: t = 44900;
      endcase
    end else begin
      case (k[2:0])
        0: t = 50175; 1: t = 56644; 3: t = 44900; 4: t = 44900;
        5: t = 50175; 7: t = 36000; default: t = 0;
      endcase
    end
    return 17'(t);
  endfunction

  task automatic check1(string what, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %0d exp %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Advance one cycle with the inputs now driven; compare at the next negedge.
  task automatic step();
    logic [4:0] k, sv;
    logic       t;
    k  = key_of();
    sv = src_of(k);
    t  = sv[4] && ref_tick[sv[3:0]];
    exp_pix = 1'b0;
    if (k != m_key || xr_div[7:6] != m_ratio) begin
      m_cnt   = 2'd0;
      m_key   = k;
      m_ratio = xr_div[7:6];
    end else if (t) begin
      if (m_cnt == m_ratio) begin
        exp_pix = 1'b1;
        m_cnt   = 2'd0;
      end else begin
        m_cnt = m_cnt + 2'd1;
      end
    end
    exp_freq  = khz_of(k);
    exp_spare = !sv[4];
    @(negedge clk);
    check1("pix_en", 32'(pix_en), 32'(exp_pix));
    check1("freq_khz", 32'(freq_khz), 32'(exp_freq));
    check1("sel_spare", 32'(sel_spare), 32'(exp_spare));
  endtask

  task automatic set_synth(logic [3:0] idx, logic [1:0] r);
    board_mode      = 2'b10;
    xr_sel_late[4]  = idx[3];
    xr_sel_gen[1]   = idx[2];
    misc_byte[3:2]  = idx[1:0];
    xr_div[7:6]     = r;
  endtask

  task automatic set_xtal(logic late, logic [2:0] c, logic [1:0] r);
    board_mode = late ? 2'b01 : 2'b00;
    if (late) xr_sel_late[4] = c[2];
    else      xr_sel_early[6] = c[2];
    misc_byte[3:2] = c[1:0];
    xr_div[7:6]    = r;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    n_vec = 0; n_bad = 0; done = 1'b0;
    board_mode = 2'b00; xr_sel_early = 8'h00; xr_sel_late = 8'h00;
    xr_sel_gen = 8'h00; xr_div = 8'h00; misc_byte = 8'h00; ref_tick = '0;
    m_key = '0; m_ratio = '0; m_cnt = '0;
    rst_n = 1'b0;
    tag = "R7";
    repeat (3) @(negedge clk);
    check1("pix_en", 32'(pix_en), 0);
    check1("freq_khz", 32'(freq_khz), 0);
    check1("sel_spare", 32'(sel_spare), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R8: synthesizer index 10, ticks elsewhere ignored
    tag = "R1";
    set_synth(4'd10, 2'd0); step();
    for (int i = 0; i < 16; i++) begin
      tag = "R1";
      ref_tick = 16'h0400; step();
      tag = "R8";
      ref_tick = 16'hFBFF; step();
    end
    ref_tick = '0;
    for (int idx = 0; idx < 16; idx++) begin
      tag = "R1";
      set_synth(4'(idx), 2'd0); ref_tick = '0; step();
      ref_tick = 16'(1 << idx); step();
      ref_tick = '0; step();
    end

    // R4: every divisor with continuous and sparse ticks
    for (int r = 0; r < 4; r++) begin
      tag = "R4";
      set_synth(4'd6, 2'(r)); ref_tick = 16'h0040; step();
      for (int c = 0; c < 13; c++) begin
        ref_tick = (c % 3 == 1) ? 16'h0000 : 16'h0040; step();
      end
    end

    // R2: both crystal revisions, all codes
    for (int lt = 0; lt < 2; lt++) begin
      for (int c = 0; c < 8; c++) begin
        tag = "R2";
        xr_sel_early = 8'h00; xr_sel_late = 8'h00;
        set_xtal(lt[0], 3'(c), 2'd1); ref_tick = '0; step();
        for (int j = 0; j < 6; j++) begin
          ref_tick = 16'h000F; step();
          ref_tick = 16'(1 << (j % 4)); step();
        end
      end
    end

    // R3: spare with every input ticking
    tag = "R3";
    set_xtal(1'b0, 3'd2, 2'd0);
    for (int j = 0; j < 8; j++) begin ref_tick = 16'hFFFF; step(); end
    set_xtal(1'b1, 3'd6, 2'd2);
    for (int j = 0; j < 8; j++) begin ref_tick = 16'hFFFF; step(); end

    // R5: change on the terminal tick, and mode swap with same effective code
    tag = "R5";
    set_synth(4'd3, 2'd2); ref_tick = 16'h0008; step();
    step(); step();
    set_synth(4'd3, 2'd3); step();
    step(); step(); step();
    set_synth(4'd9, 2'd3); ref_tick = 16'h0208; step();
    for (int j = 0; j < 6; j++) step();
    xr_sel_early = 8'h40; xr_sel_late = 8'h00;
    set_xtal(1'b0, 3'd5, 2'd1); ref_tick = 16'h0001; step(); step();
    xr_sel_late[4] = 1'b1; board_mode = 2'b01; step(); step(); step();

    // R6: frequency report over every selection class
    tag = "R6";
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 32; c++) begin
        board_mode = 2'(m);
        xr_sel_early[6] = c[4]; xr_sel_late[4] = c[3];
        xr_sel_gen[1] = c[2]; misc_byte[3:2] = 2'(c);
        ref_tick = '0; step();
      end
    end

    // Random phase
    tag = "R4";
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 39) == 0) begin
        board_mode   = 2'($urandom);
        xr_sel_early = 8'($urandom);
        xr_sel_late  = 8'($urandom);
        xr_sel_gen   = 8'($urandom);
        xr_div       = 8'($urandom);
        misc_byte    = 8'($urandom);
        tag = "R5";
      end else begin
        tag = "R4";
      end
      ref_tick = 16'($urandom) & 16'($urandom);
      step();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule